// File: doc/BRIEF.md
# Addressed Strobe Control Bus

This block carries register writes from one control master to several components over a single shared bus. Host software loads a small set of master registers: the target component number, a starting register offset, a word count and up to four data words. It then sets a start bit. The master sends one header word, followed by the data words, across the shared bus. Each word stays on the bus for a fixed number of cycles, so the bus can be timed as a multicycle path.

The master decodes the component number into a private strobe line for that one component. Each strobe line runs through its own short chain of registers before it reaches the component. A small receiver in each component counts cycles from the arrival of its strobe. It samples the header word, which holds the offset and the count, and then turns each later data word into a one-cycle write pulse with an address and data. The offsets are local to the component, so identical components share one register map.

When the last word has been delivered and the strobe has drained, the master sets a done flag and waits for the next command. Each component also drives an event line back to the master. Event lines are caught in sticky per-component pending bits that the host clears.

Top module: `strobe_ctrl_bus`

## Requirements
- R1: During a transfer to component N (N below NUM_COMP = 4), compStrobe has only bit N set. At no time is more than one strobe bit high, and every write pulse comes from the addressed component.
- R2: A transfer to a component number that no component owns (4 to 7) raises no strobe and no write pulse. It still ends with the done flag set, on the same timing as a transfer to a component that exists.
- R3: Host writes select a register by hostSel:
  - 0: component number.
  - 1: starting register offset.
  - 2: word count.
  - 3: appends one data word. At most four are kept, and further appends are dropped.
  - 4: control. Bit 0 starts a transfer, bit 1 clears the event bits, bit 2 clears done.

  Each loaded data word reaches the target as exactly one write pulse, in load order, carrying that data.
- R4: The first write uses the starting offset. Each later write uses the previous address plus one, wrapping modulo 16.
- R5: The start write is captured at a clock edge. busy is high from the next cycle on. done is first seen (W*3)+3 cycles after the first busy cycle, where W is the effective count plus one. Starting a transfer clears done, and done and busy are never high together.
- R6: The first write pulse appears 6 cycles after the first busy cycle. Each bus word is held for 3 cycles, which is the chain length of 2 plus one.
- R7: A word count above 4 is treated as 4. A count of 0 sends only the header, produces no write, and sets done 6 cycles after the first busy cycle.
- R8: While busy is high, host writes to selects 0 to 3 and start requests are ignored. The transfer in progress keeps its timing, and later transfers use the earlier settings.
- R9: A high level on compEvent[N] sets eventPending[N] in the next cycle. The bit stays set until a control write with bit 1. eventAny is the OR of the pending bits. An event in the same cycle as a clear wins over the clear.
- R10: A control write with bit 2 clears done.
- R11: After reset, busy, done, all strobes, all write pulses and all pending bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWe | input | 1 | Host register write enable |
| hostSel | input | 3 | Host register select |
| hostWdata | input | 16 | Host write data |
| compEvent | input | 4 | Event lines from the components |
| busy | output | 1 | Transfer in progress |
| doneFlag | output | 1 | Last transfer complete |
| eventPending | output | 4 | Sticky pending bit per component |
| eventAny | output | 1 | OR of the pending bits |
| compStrobe | output | 4 | Delayed strobe as seen by each component |
| compRegWe | output | 4 | Write pulse per component |
| compRegAddr | output | 16 | 4-bit register offset per component |
| compRegData | output | 64 | 16-bit write data per component |

## Verification
Counting from the first cycle in which busy is high, the first write pulse is due 6 cycles later. Later writes follow every 3 cycles. done is due (count+1)*3+3 cycles in, and a cleared or newly raised event bit is due one cycle after its stimulus. The bench keeps a free-running cycle counter sampled on the falling edge and marks the cycle after the start edge as its origin. Each of these offsets is compared exactly against that origin. Write pulses are matched against a queue of expected component, address and data triples, and the queue must be empty once done is seen.

// File: rtl/strobe_bus_pkg.sv
package strobe_bus_pkg;

  localparam logic [2:0] SEL_COMP  = 3'd0;
  localparam logic [2:0] SEL_REG   = 3'd1;
  localparam logic [2:0] SEL_COUNT = 3'd2;
  localparam logic [2:0] SEL_DATA  = 3'd3;
  localparam logic [2:0] SEL_CTRL  = 3'd4;

  // Bit position of the word count inside the header word.
  localparam int HDR_CNT_LSB = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_XFER,
    ST_DRAIN
  } xfer_state_t;

  // Sequencing strobes from control to datapath.
  typedef struct packed {
    logic capture;   // latch settings, drive header, raise strobe
    logic nextWord;  // drive next data word
    logic endXfer;   // drop strobe and bus
    logic setDone;   // raise done flag
  } ctl_strobe_t;

endpackage

// File: rtl/strobe_delay_line.sv
module strobe_delay_line #(
  parameter int WIDTH = 1,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] sigIn,
  output logic [WIDTH-1:0] sigOut
);

  generate
    if (DEPTH == 0) begin : g_wire
      assign sigOut = sigIn;
    end else begin : g_regs
      logic [WIDTH-1:0] stage [DEPTH];
      always_ff @(posedge clk) begin
        if (!rstN) begin
          for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
        end else begin
          stage[0] <= sigIn;
          for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
        end
      end
      assign sigOut = stage[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/strobe_bus_ctrl.sv
module strobe_bus_ctrl
  import strobe_bus_pkg::*;
#(
  parameter int HOLD  = 3,
  parameter int DLY   = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [CNT_W-1:0] latchedCount,
  output ctl_strobe_t      ctl,
  output logic             busy
);

  localparam int HC_W = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam int DC_W = (DLY > 0) ? $clog2(DLY + 1) : 1;

  xfer_state_t      state;
  logic [HC_W-1:0]  holdCnt;
  logic [DC_W-1:0]  drainCnt;
  logic [CNT_W-1:0] wordNum;
  logic             lastHold;
  logic             lastWord;

  assign lastHold = (holdCnt == HC_W'(HOLD - 1));
  assign lastWord = (wordNum == latchedCount);
  assign busy     = (state != ST_IDLE);

  always_comb begin
    ctl          = '0;
    ctl.capture  = (state == ST_IDLE) && startReq;
    ctl.nextWord = (state == ST_XFER) && lastHold && !lastWord;
    ctl.endXfer  = (state == ST_XFER) && lastHold && lastWord;
    ctl.setDone  = (state == ST_DRAIN) && (drainCnt == DC_W'(DLY));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      holdCnt  <= '0;
      drainCnt <= '0;
      wordNum  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (ctl.capture) begin
            state   <= ST_XFER;
            holdCnt <= '0;
            wordNum <= '0;
          end
        end
        ST_XFER: begin
          if (lastHold) begin
            holdCnt <= '0;
            if (lastWord) begin
              state    <= ST_DRAIN;
              drainCnt <= '0;
            end else begin
              wordNum <= wordNum + 1'b1;
            end
          end else begin
            holdCnt <= holdCnt + 1'b1;
          end
        end
        ST_DRAIN: begin
          if (ctl.setDone) state <= ST_IDLE;
          else drainCnt <= drainCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/strobe_bus_dpath.sv
module strobe_bus_dpath
  import strobe_bus_pkg::*;
#(
  parameter int NUM_COMP  = 4,
  parameter int CA_W      = 3,
  parameter int REG_AW    = 4,
  parameter int DATA_W    = 16,
  parameter int CNT_W     = 3,
  parameter int MAX_WORDS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                hostWe,
  input  logic [2:0]          hostSel,
  input  logic [DATA_W-1:0]   hostWdata,
  input  logic [NUM_COMP-1:0] compEvent,
  input  logic                busy,
  input  ctl_strobe_t         ctl,
  output logic [CNT_W-1:0]    latchedCount,
  output logic [DATA_W-1:0]   busWord,
  output logic [NUM_COMP-1:0] rawStrobe,
  output logic                doneFlag,
  output logic [NUM_COMP-1:0] eventPending,
  output logic                eventAny
);

  localparam int IDX_W = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1;
  localparam int PTR_W = $clog2(MAX_WORDS + 1);

  logic [CA_W-1:0]     cfgComp;
  logic [REG_AW-1:0]   cfgReg;
  logic [CNT_W-1:0]    cfgCount;
  logic [CNT_W-1:0]    effCount;
  logic [DATA_W-1:0]   dataBuf [MAX_WORDS];
  logic [PTR_W-1:0]    wrPtr;
  logic [IDX_W-1:0]    rdPtr;
  logic [DATA_W-1:0]   hdrWord;
  logic [NUM_COMP-1:0] decoded;
  logic                hostAccept;
  logic                ctrlWrite;
  logic                clrEvents;

  assign hostAccept = hostWe && !busy;
  assign ctrlWrite  = hostWe && (hostSel == SEL_CTRL);
  assign clrEvents  = ctrlWrite && hostWdata[1];

  always_comb begin
    effCount = (cfgCount > CNT_W'(MAX_WORDS)) ? CNT_W'(MAX_WORDS) : cfgCount;
  end

  always_comb begin
    hdrWord                         = '0;
    hdrWord[REG_AW-1:0]             = cfgReg;
    hdrWord[HDR_CNT_LSB +: CNT_W]   = effCount;
  end

  generate
    for (genvar i = 0; i < NUM_COMP; i++) begin : g_decode
      assign decoded[i] = (cfgComp == CA_W'(i));
    end
  endgenerate

  // Host-loaded settings and data words.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgComp  <= '0;
      cfgReg   <= '0;
      cfgCount <= '0;
      wrPtr    <= '0;
      for (int i = 0; i < MAX_WORDS; i++) dataBuf[i] <= '0;
    end else begin
      if (ctl.capture) begin
        wrPtr <= '0;
      end else if (hostAccept) begin
        case (hostSel)
          SEL_COMP:  cfgComp  <= hostWdata[CA_W-1:0];
          SEL_REG:   cfgReg   <= hostWdata[REG_AW-1:0];
          SEL_COUNT: cfgCount <= hostWdata[CNT_W-1:0];
          SEL_DATA: begin
            if (wrPtr < PTR_W'(MAX_WORDS)) begin
              dataBuf[wrPtr[IDX_W-1:0]] <= hostWdata;
              wrPtr <= wrPtr + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // Bus word, strobe source and transfer sequencing.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      busWord      <= '0;
      rawStrobe    <= '0;
      latchedCount <= '0;
      rdPtr        <= '0;
    end else begin
      if (ctl.capture) begin
        busWord      <= hdrWord;
        rawStrobe    <= decoded;
        latchedCount <= effCount;
        rdPtr        <= '0;
      end else if (ctl.nextWord) begin
        busWord <= dataBuf[rdPtr];
        rdPtr   <= rdPtr + 1'b1;
      end else if (ctl.endXfer) begin
        busWord   <= '0;
        rawStrobe <= '0;
      end
    end
  end

  // Done flag and sticky events.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneFlag     <= 1'b0;
      eventPending <= '0;
    end else begin
      if (ctl.setDone) doneFlag <= 1'b1;
      else if (ctl.capture) doneFlag <= 1'b0;
      else if (ctrlWrite && hostWdata[2]) doneFlag <= 1'b0;

      if (clrEvents) eventPending <= compEvent;
      else eventPending <= eventPending | compEvent;
    end
  end

  assign eventAny = |eventPending;

endmodule

// File: rtl/strobe_bus_endpoint.sv
module strobe_bus_endpoint
  import strobe_bus_pkg::*;
#(
  parameter int REG_AW = 4,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 3,
  parameter int HOLD   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strobe,
  input  logic [DATA_W-1:0] busWord,
  output logic              regWe,
  output logic [REG_AW-1:0] regAddr,
  output logic [DATA_W-1:0] regData
);

  localparam int HC_W = (HOLD > 1) ? $clog2(HOLD) : 1;

  logic [HC_W-1:0]   phaseCnt;
  logic              awaitHdr;
  logic [REG_AW-1:0] curAddr;
  logic [CNT_W-1:0]  remaining;
  logic              sampleNow;

  assign sampleNow = strobe && (phaseCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseCnt  <= '0;
      awaitHdr  <= 1'b1;
      curAddr   <= '0;
      remaining <= '0;
      regWe     <= 1'b0;
      regAddr   <= '0;
      regData   <= '0;
    end else begin
      regWe <= 1'b0;
      if (!strobe) begin
        phaseCnt <= '0;
        awaitHdr <= 1'b1;
      end else if (phaseCnt == HC_W'(HOLD - 1)) begin
        phaseCnt <= '0;
      end else begin
        phaseCnt <= phaseCnt + 1'b1;
      end

      if (sampleNow) begin
        if (awaitHdr) begin
          curAddr   <= busWord[REG_AW-1:0];
          remaining <= busWord[HDR_CNT_LSB +: CNT_W];
          awaitHdr  <= 1'b0;
        end else if (remaining != '0) begin
          regWe     <= 1'b1;
          regAddr   <= curAddr;
          regData   <= busWord;
          curAddr   <= curAddr + 1'b1;
          remaining <= remaining - 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/strobe_ctrl_bus.sv
module strobe_ctrl_bus
  import strobe_bus_pkg::*;
#(
  parameter int NUM_COMP  = 4,
  parameter int CA_W      = 3,
  parameter int REG_AW    = 4,
  parameter int DATA_W    = 16,
  parameter int MAX_WORDS = 4,
  parameter int DLY       = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       hostWe,
  input  logic [2:0]                 hostSel,
  input  logic [DATA_W-1:0]          hostWdata,
  input  logic [NUM_COMP-1:0]        compEvent,
  output logic                       busy,
  output logic                       doneFlag,
  output logic [NUM_COMP-1:0]        eventPending,
  output logic                       eventAny,
  output logic [NUM_COMP-1:0]        compStrobe,
  output logic [NUM_COMP-1:0]        compRegWe,
  output logic [NUM_COMP*REG_AW-1:0] compRegAddr,
  output logic [NUM_COMP*DATA_W-1:0] compRegData
);

  localparam int HOLD  = DLY + 1;
  localparam int CNT_W = $clog2(MAX_WORDS + 1);

  ctl_strobe_t         ctl;
  logic                startReq;
  logic [CNT_W-1:0]    latchedCount;
  logic [DATA_W-1:0]   busWord;
  logic [NUM_COMP-1:0] rawStrobe;

  assign startReq = hostWe && (hostSel == SEL_CTRL) && hostWdata[0];

  strobe_bus_ctrl #(
    .HOLD (HOLD),
    .DLY  (DLY),
    .CNT_W(CNT_W)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startReq    (startReq),
    .latchedCount(latchedCount),
    .ctl         (ctl),
    .busy        (busy)
  );

  strobe_bus_dpath #(
    .NUM_COMP (NUM_COMP),
    .CA_W     (CA_W),
    .REG_AW   (REG_AW),
    .DATA_W   (DATA_W),
    .CNT_W    (CNT_W),
    .MAX_WORDS(MAX_WORDS)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .hostWe      (hostWe),
    .hostSel     (hostSel),
    .hostWdata   (hostWdata),
    .compEvent   (compEvent),
    .busy        (busy),
    .ctl         (ctl),
    .latchedCount(latchedCount),
    .busWord     (busWord),
    .rawStrobe   (rawStrobe),
    .doneFlag    (doneFlag),
    .eventPending(eventPending),
    .eventAny    (eventAny)
  );

  generate
    for (genvar i = 0; i < NUM_COMP; i++) begin : g_comp
      strobe_delay_line #(
        .WIDTH(1),
        .DEPTH(DLY)
      ) u_chain (
        .clk   (clk),
        .rstN  (rstN),
        .sigIn (rawStrobe[i]),
        .sigOut(compStrobe[i])
      );

      strobe_bus_endpoint #(
        .REG_AW(REG_AW),
        .DATA_W(DATA_W),
        .CNT_W (CNT_W),
        .HOLD  (HOLD)
      ) u_ep (
        .clk    (clk),
        .rstN   (rstN),
        .strobe (compStrobe[i]),
        .busWord(busWord),
        .regWe  (compRegWe[i]),
        .regAddr(compRegAddr[i*REG_AW +: REG_AW]),
        .regData(compRegData[i*DATA_W +: DATA_W])
      );
    end
  endgenerate

endmodule

// File: rtl/strobe_ctrl_bus_chk.sv
module strobe_ctrl_bus_chk #(
  parameter int NUM_COMP = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                clrReq,
  input logic                busy,
  input logic                doneFlag,
  input logic [NUM_COMP-1:0] compEvent,
  input logic [NUM_COMP-1:0] eventPending,
  input logic [NUM_COMP-1:0] compStrobe,
  input logic [NUM_COMP-1:0] compRegWe
);

  // R1
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(compStrobe));

  // R2
  strobe_in_xfer_chk: assert property (@(posedge clk) disable iff (!rstN)
    (compStrobe != '0) |-> busy);

  // R3
  write_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (compRegWe != '0) |-> ((compRegWe & ~$past(compStrobe)) == '0));

  // R5
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && doneFlag));

  // R5
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> $past(busy));

  // R9
  event_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (compEvent != '0) |=> ((eventPending & $past(compEvent)) == $past(compEvent)));

  // R9
  event_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clrReq |=> ((eventPending & $past(eventPending)) == $past(eventPending)));

endmodule

bind strobe_ctrl_bus strobe_ctrl_bus_chk #(.NUM_COMP(NUM_COMP)) chk (
  .clk         (clk),
  .rstN        (rstN),
  .clrReq      (hostWe && (hostSel == 3'd4) && hostWdata[1]),
  .busy        (busy),
  .doneFlag    (doneFlag),
  .compEvent   (compEvent),
  .eventPending(eventPending),
  .compStrobe  (compStrobe),
  .compRegWe   (compRegWe)
);

// File: tb/strobe_ctrl_bus_test.sv
module strobe_ctrl_bus_test;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_COMP   = 4;
  localparam int DLY        = 2;
  localparam int HOLD       = DLY + 1;

  logic                clk = 1'b0;
  logic                rstN;
  logic                hostWe;
  logic [2:0]          hostSel;
  logic [15:0]         hostWdata;
  logic [3:0]          compEvent;
  logic                busy;
  logic                doneFlag;
  logic [3:0]          eventPending;
  logic                eventAny;
  logic [3:0]          compStrobe;
  logic [3:0]          compRegWe;
  logic [15:0]         compRegAddr;
  logic [63:0]         compRegData;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit finished = 1'b0;

  typedef struct {
    int comp;
    int addr;
    int data;
  } wr_t;

  wr_t expQ[$];

  strobe_ctrl_bus uut (
    .clk         (clk),
    .rstN        (rstN),
    .hostWe      (hostWe),
    .hostSel     (hostSel),
    .hostWdata   (hostWdata),
    .compEvent   (compEvent),
    .busy        (busy),
    .doneFlag    (doneFlag),
    .eventPending(eventPending),
    .eventAny    (eventAny),
    .compStrobe  (compStrobe),
    .compRegWe   (compRegWe),
    .compRegAddr (compRegAddr),
    .compRegData (compRegData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every write pulse.
  always @(negedge clk) begin
    wr_t e;
    if (rstN) begin
      for (int i = 0; i < NUM_COMP; i++) begin
        if (compRegWe[i]) begin
          if (expQ.size() == 0) begin
            check(1'b0, "R2/R3 unexpected write on component", i, -1);
          end else begin
            e = expQ.pop_front();
            check(i == e.comp, "R1 write component", i, e.comp);
            check(int'(compRegAddr[i*4 +: 4]) == e.addr, "R4 write address",
                  int'(compRegAddr[i*4 +: 4]), e.addr);
            check(int'(compRegData[i*16 +: 16]) == e.data, "R3 write data",
                  int'(compRegData[i*16 +: 16]), e.data);
          end
        end
      end
    end
  end

  task automatic hostWrite(input int sel, input int val);
    hostWe    = 1'b1;
    hostSel   = sel[2:0];
    hostWdata = val[15:0];
    @(negedge clk);
    hostWe    = 1'b0;
  endtask

  // Driver: loads settings, pushes expected writes, starts, then times the result.
  task automatic runXfer(input int comp, input int regA, input int cnt, input int seed,
                         input bit pokeBusy, input bit skipCfg);
    int eff;
    bit valid;
    int c0;
    int lat;
    int firstWe;
    int doneLat;
    logic [3:0] strobeSeen;
    eff   = (cnt > 4) ? 4 : cnt;
    valid = (comp < NUM_COMP);
    if (!skipCfg) begin
      hostWrite(0, comp);
      hostWrite(1, regA);
      hostWrite(2, cnt);
    end
    for (int k = 0; k < cnt; k++) begin
      int d;
      d = (seed + k * 4099) & 16'hFFFF;
      hostWrite(3, d);
      if (valid && k < eff) expQ.push_back('{comp, (regA + k) % 16, d});
    end
    hostWrite(4, 1);
    c0 = cyc;
    firstWe = -1;
    strobeSeen = '0;
    lat = 0;
    while (!doneFlag && lat < 100) begin
      if (pokeBusy) begin
        if (lat == 3) begin hostWe = 1'b1; hostSel = 3'd4; hostWdata = 16'd1; end
        if (lat == 4) begin hostSel = 3'd0; hostWdata = 16'd2; end
        if (lat == 5) begin hostSel = 3'd2; hostWdata = 16'd4; end
        if (lat == 6) hostWe = 1'b0;
      end
      strobeSeen = strobeSeen | compStrobe;
      if (firstWe < 0 && compRegWe != '0) firstWe = lat;
      @(negedge clk);
      lat = cyc - c0;
    end
    doneLat = cyc - c0;
    check(doneFlag == 1'b1, "R5 done set", int'(doneFlag), 1);
    check(busy == 1'b0, "R5 busy low at done", int'(busy), 0);
    check(doneLat == (eff + 1) * HOLD + DLY + 1, "R5/R7 done latency",
          doneLat, (eff + 1) * HOLD + DLY + 1);
    if (valid && eff > 0)
      check(firstWe == DLY + HOLD + 1, "R6 first write latency", firstWe, DLY + HOLD + 1);
    check(strobeSeen == (valid ? (4'b1 << comp) : 4'b0), "R1/R2 strobe lines",
          int'(strobeSeen), valid ? (1 << comp) : 0);
    check(expQ.size() == 0, "R3 all writes delivered", expQ.size(), 0);
    expQ.delete();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R5 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    hostWe = 1'b0;
    hostSel = '0;
    hostWdata = '0;
    compEvent = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 reset state
    check(busy == 1'b0, "R11 busy after reset", int'(busy), 0);
    check(doneFlag == 1'b0, "R11 done after reset", int'(doneFlag), 0);
    check(compStrobe == '0, "R11 strobes after reset", int'(compStrobe), 0);
    check(compRegWe == '0, "R11 writes after reset", int'(compRegWe), 0);
    check(eventPending == '0, "R11 events after reset", int'(eventPending), 0);

    // R1 R3 R4 R5 R6: basic transfer
    runXfer(1, 5, 3, 16'h1234, 1'b0, 1'b0);
    // R10 done clear
    hostWrite(4, 4);
    check(doneFlag == 1'b0, "R10 done cleared", int'(doneFlag), 0);

    // R4 address wrap
    runXfer(3, 14, 4, 16'hA5A5, 1'b0, 1'b0);
    // R1 single word to component 0
    runXfer(0, 0, 1, 16'h0F0F, 1'b0, 1'b0);
    // R2 unused component number
    runXfer(6, 2, 2, 16'h7777, 1'b0, 1'b0);
    // R7 zero count
    runXfer(2, 9, 0, 16'h0000, 1'b0, 1'b0);
    // R7 count above limit clamps to 4
    runXfer(2, 1, 6, 16'h4321, 1'b0, 1'b0);

    // R8 writes while busy ignored, then reuse of the earlier settings
    runXfer(1, 3, 2, 16'h5151, 1'b1, 1'b0);
    runXfer(1, 3, 2, 16'h6262, 1'b0, 1'b1);

    // R9 sticky events
    compEvent = 4'b0100;
    @(negedge clk);
    compEvent = 4'b0000;
    check(eventPending == 4'b0100, "R9 event captured", int'(eventPending), 4);
    check(eventAny == 1'b1, "R9 eventAny", int'(eventAny), 1);
    repeat (3) @(negedge clk);
    check(eventPending == 4'b0100, "R9 event sticky", int'(eventPending), 4);
    compEvent = 4'b1001;
    @(negedge clk);
    compEvent = 4'b0000;
    check(eventPending == 4'b1101, "R9 events merge", int'(eventPending), 13);
    hostWrite(4, 2);
    check(eventPending == 4'b0000, "R9 events cleared", int'(eventPending), 0);
    check(eventAny == 1'b0, "R9 eventAny cleared", int'(eventAny), 0);
    // R9 event in same cycle as clear wins
    compEvent = 4'b0010;
    hostWrite(4, 2);
    compEvent = 4'b0000;
    check(eventPending == 4'b0010, "R9 event beats clear", int'(eventPending), 2);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule